// File: doc/BRIEF.md
# Ethernet Transmit Retry and Collision Controller

This block supervises the transmit side of one half-duplex Ethernet port. It follows a frame attempt from its start strobe to its end, counts byte times to tell an ordinary collision from a late one, and tracks consecutive collisions across attempts of the same frame. It also watches for FIFO underflow and for carrier-sense faults.

Every attempt ends in one of two ways. If the fault can be recovered by backing off, the block emits a backoff-start pulse. If the frame cannot complete, it raises a latched retry request, pulses a FIFO flush and drops transmit-ready until the host clears the request.

On every attempt end a 16-bit transmit status word is reloaded. An interrupt pulse fires when any of its flag bits is enabled in the command mask.

Top module: `tx_retry_ctrl`

## Requirements
- R1: After reset, retry_o, flush_o, backoff_o and irq_o are low, txrdy_o is high and tx_status_o is zero.
- R2: tx_start_i begins an attempt only when no attempt is active and retry_o is low. While retry_o is high a start strobe is ignored: a following collision changes neither tx_status_o nor backoff_o. Attempt inputs other than tx_start_i are ignored outside an attempt.
- R3: A collision that is not late ends the attempt. One cycle later tx_status_o is reloaded with bit 0 (collision) set and backoff_o pulses for one cycle.
- R4: Byte ticks are counted from the attempt start, saturating above the limit (64). A collision is late when more than 64 ticks have been counted before the collision cycle. A late collision sets status bit 3, ends the attempt and raises retry, with no backoff pulse. A collision after exactly 64 ticks is an ordinary collision.
- R5: The 16th consecutive non-late collision sets status bits 4 and 0, reports 16 in bits 15:11, raises retry and still pulses backoff_o.
- R6: The consecutive-collision counter is 4 bits wide and wraps on the 16th collision. The 17th consecutive collision is therefore treated as the first of a new run: it reports 1 attempt and raises no retry.
- R7: With one_try_i high, any non-late collision sets status bit 0 and raises retry.
- R8: Underflow during an attempt ends it, sets status bit 1 and raises retry.
- R9: Status bit 2 is set and retry is raised in two cases. The first is carrier sense dropping from high to low during an attempt, outside the end-of-frame cycle. The second is carrier sense never going high by the time of end of frame.
- R10: When retry is raised, flush_o pulses in the same cycle and txrdy_o goes low. retry_o stays high until retry_clr_i, after which txrdy_o returns high.
- R11: A fault-free end of frame sets status bit 5 and clears the collision counter. Status bits 15:11 always hold the number of the attempt that just ended (consecutive collisions before it, plus one).
- R12: irq_o pulses together with a status reload when the reloaded bits 5:0 ANDed with cmd_en_i are non-zero, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_start_i | input | 1 | Start of a frame attempt |
| byte_tick_i | input | 1 | One byte time transmitted |
| coll_i | input | 1 | Collision detected |
| crs_i | input | 1 | Carrier sense level |
| underflow_i | input | 1 | Transmit FIFO underflow |
| eof_i | input | 1 | End of frame reached |
| one_try_i | input | 1 | Abort on the first collision |
| retry_clr_i | input | 1 | Host acknowledge of a retry request |
| cmd_en_i | input | 6 | Interrupt enables for status bits 5:0 |
| retry_o | output | 1 | Latched retry request |
| flush_o | output | 1 | FIFO flush pulse |
| txrdy_o | output | 1 | Transmit ready |
| backoff_o | output | 1 | Backoff start pulse |
| tx_status_o | output | 16 | Transmit status of the last attempt |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench drives several kinds of attempt. Clean frames separate the success path from the fault paths. Collisions after exactly 64 and exactly 65 byte ticks pin the late-collision boundary. A run of 16 collisions followed by a 17th shows both the 16-attempt abort and the counter wrap. Underflow, missing carrier, dropped carrier and one-try collisions show that each cause sets its own flag and shares the retry, flush and ready behaviour. A start strobe issued during a pending retry, and switching the interrupt mask, show what is ignored and what is filtered.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;
  localparam int ST_W   = 16;
  localparam int ATT_W  = 5;
  localparam int CNT_W  = 4;
  localparam int FLAG_W = 6;

  typedef struct packed {
    logic [ATT_W-1:0]             attempts;
    logic [ST_W-ATT_W-FLAG_W-1:0] rsvd;
    logic                         ok;
    logic                         sixteen;
    logic                         late;
    logic                         carrier;
    logic                         underflow;
    logic                         coll;
  } tx_status_t;
endpackage

// File: rtl/tx_byte_timer.sv
module tx_byte_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic late_o
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] SAT = W'(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + W'(1);
  end

  assign late_o = (cnt_q > W'(LIMIT));
endmodule

// File: rtl/tx_attempt_ctr.sv
module tx_attempt_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  // modulo 2**W: wraps on the last collision of a run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
    else if (clr_i)  cnt_q <= '0;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;
endmodule

// File: rtl/tx_carrier_mon.sv
module tx_carrier_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic act_i,
  input  logic crs_i,
  input  logic eof_i,
  output logic drop_o,
  output logic none_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= 1'b0;
    else if (clr_i)          seen_q <= 1'b0;
    else if (act_i && crs_i) seen_q <= 1'b1;
  end

  assign drop_o = act_i && seen_q && !crs_i && !eof_i;
  assign none_o = act_i && eof_i && !seen_q && !crs_i;
endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl
  import tx_retry_pkg::*;
#(
  parameter int LATE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_start_i,
  input  logic              byte_tick_i,
  input  logic              coll_i,
  input  logic              crs_i,
  input  logic              underflow_i,
  input  logic              eof_i,
  input  logic              one_try_i,
  input  logic              retry_clr_i,
  input  logic [FLAG_W-1:0] cmd_en_i,
  output logic              retry_o,
  output logic              flush_o,
  output logic              txrdy_o,
  output logic              backoff_o,
  output logic [ST_W-1:0]   tx_status_o,
  output logic              irq_o
);
  logic active_q, retry_q, flush_q, backoff_q, irq_q, load_q;
  tx_status_t st_q, st_n;

  logic start_ok, late_win, crs_drop, crs_none;
  logic [CNT_W-1:0] att_cnt;
  logic att_last;
  logic ev_coll, ev_late, ev_ncoll, ev_six, ev_und, ev_crs, ev_eof, ev_ok, ev_end, ev_retry;

  assign start_ok = tx_start_i && !active_q && !retry_q;

  tx_byte_timer #(.LIMIT(LATE_BYTES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .tick_i (active_q && byte_tick_i),
    .late_o (late_win)
  );

  tx_attempt_ctr #(.W(CNT_W)) u_att (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ev_ncoll),
    .clr_i  (ev_ok),
    .cnt_o  (att_cnt),
    .last_o (att_last)
  );

  tx_carrier_mon u_crs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .act_i  (active_q),
    .crs_i  (crs_i),
    .eof_i  (eof_i),
    .drop_o (crs_drop),
    .none_o (crs_none)
  );

  assign ev_coll  = active_q && coll_i;
  assign ev_late  = ev_coll && late_win;
  assign ev_ncoll = ev_coll && !late_win;
  assign ev_six   = ev_ncoll && att_last;
  assign ev_und   = active_q && underflow_i;
  assign ev_crs   = crs_drop || crs_none;
  assign ev_eof   = active_q && eof_i;
  assign ev_ok    = ev_eof && !ev_coll && !ev_und && !ev_crs;
  assign ev_end   = ev_coll || ev_und || ev_crs || ev_eof;
  assign ev_retry = ev_und || ev_late || ev_crs || ev_six || (ev_ncoll && one_try_i);

  always_comb begin
    st_n           = '0;
    st_n.attempts  = ATT_W'(att_cnt) + ATT_W'(1);
    st_n.coll      = ev_ncoll;
    st_n.underflow = ev_und;
    st_n.carrier   = ev_crs;
    st_n.late      = ev_late;
    st_n.sixteen   = ev_six;
    st_n.ok        = ev_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      retry_q   <= 1'b0;
      flush_q   <= 1'b0;
      backoff_q <= 1'b0;
      irq_q     <= 1'b0;
      load_q    <= 1'b0;
      st_q      <= '0;
    end else begin
      if (start_ok)    active_q <= 1'b1;
      else if (ev_end) active_q <= 1'b0;
      if (ev_retry)         retry_q <= 1'b1;
      else if (retry_clr_i) retry_q <= 1'b0;
      flush_q   <= ev_retry;
      backoff_q <= ev_ncoll;
      load_q    <= ev_end;
      irq_q     <= ev_end && ((st_n[FLAG_W-1:0] & cmd_en_i) != '0);
      if (ev_end) st_q <= st_n;
    end
  end

  assign retry_o     = retry_q;
  assign flush_o     = flush_q;
  assign txrdy_o     = !retry_q;
  assign backoff_o   = backoff_q;
  assign tx_status_o = st_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/tx_retry_ctrl_chk.sv
module tx_retry_ctrl_chk
  import tx_retry_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retry_o,
  input logic              flush_o,
  input logic              backoff_o,
  input logic              irq_o,
  input logic              load_q,
  input logic              retry_clr_i,
  input logic [FLAG_W-1:0] cmd_en_i,
  input logic [ST_W-1:0]   tx_status_o
);
  p_flush_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> retry_o && !$past(retry_o));

  p_retry_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o && !retry_clr_i |=> retry_o);

  p_backoff_coll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backoff_o |-> load_q && tx_status_o[0]);

  p_late_retry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q && tx_status_o[3] |-> retry_o && !backoff_o);

  p_sixteen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q && tx_status_o[4] |-> tx_status_o[0] && retry_o && tx_status_o[15:11] == 5'd16);

  p_ok_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q && tx_status_o[5] |-> tx_status_o[4:0] == 5'd0 && !flush_o);

  p_irq_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> load_q && ((tx_status_o[FLAG_W-1:0] & $past(cmd_en_i)) != '0));

  p_status_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> $stable(tx_status_o));
endmodule

bind tx_retry_ctrl tx_retry_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .retry_o     (retry_o),
  .flush_o     (flush_o),
  .backoff_o   (backoff_o),
  .irq_o       (irq_o),
  .load_q      (load_q),
  .retry_clr_i (retry_clr_i),
  .cmd_en_i    (cmd_en_i),
  .tx_status_o (tx_status_o)
);

// File: tb/test_tx_retry_ctrl.sv
module test_tx_retry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, tick = 0, coll = 0, crs = 1, under = 0, eof = 0, one = 0, clr = 0;
  logic [5:0] en = 6'h20;
  logic retry, flush, txrdy, backoff, irq;
  logic [15:0] status;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_active = 0, m_bytes = 0, m_seen = 0, m_cnt = 0;
  bit m_retry = 0, m_flush = 0, m_backoff = 0, m_irq = 0;
  logic [15:0] m_status = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_retry_ctrl i_tx_retry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tx_start_i(start), .byte_tick_i(tick),
    .coll_i(coll), .crs_i(crs), .underflow_i(under), .eof_i(eof),
    .one_try_i(one), .retry_clr_i(clr), .cmd_en_i(en),
    .retry_o(retry), .flush_o(flush), .txrdy_o(txrdy), .backoff_o(backoff),
    .tx_status_o(status), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit e_coll, late, ncoll, six, und, cf, ef, e_end, rty, ok;
    logic [15:0] st;
    e_coll = m_active != 0 && coll;
    late   = e_coll && m_bytes > 64;
    ncoll  = e_coll && !late;
    six    = ncoll && m_cnt == 15;
    und    = m_active != 0 && under;
    cf     = m_active != 0 && ((m_seen != 0 && !crs && !eof) || (eof && m_seen == 0 && !crs));
    ef     = m_active != 0 && eof;
    e_end  = e_coll || und || cf || ef;
    rty    = und || late || cf || six || (ncoll && one);
    ok     = ef && !e_coll && !und && !cf;
    st = 16'((m_cnt + 1) << 11);
    st[0] = ncoll; st[1] = und; st[2] = cf; st[3] = late; st[4] = six; st[5] = ok;
    m_flush   = rty;
    m_backoff = ncoll;
    m_irq     = e_end && ((st[5:0] & en) != 0);
    if (e_end) m_status = st;
    if (ncoll) m_cnt = (m_cnt + 1) % 16;
    else if (ok) m_cnt = 0;
    if (m_active == 0 && start && !m_retry) begin
      m_active = 1; m_bytes = 0; m_seen = 0;
    end else if (m_active != 0) begin
      if (e_end) m_active = 0;
      else begin
        if (tick && m_bytes < 65) m_bytes++;
        if (crs) m_seen = 1;
      end
    end
    if (rty) m_retry = 1;
    else if (clr) m_retry = 0;
  endtask

  task automatic compare();
    chk("R10 retry", retry, m_retry);
    chk("R10 txrdy", txrdy, !m_retry);
    chk("R10 flush", flush, m_flush);
    chk("R3 backoff", backoff, m_backoff);
    chk("R11 status", status, m_status);
    chk("R12 irq", irq, m_irq);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    start = 0; tick = 0; coll = 0; under = 0; eof = 0; clr = 0;
  endtask

  task automatic go();
    start = 1; cycle();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cycle(); end
  endtask

  task automatic ack();
    clr = 1; cycle(); cycle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 retry", retry, 0); chk("R1 txrdy", txrdy, 1); chk("R1 flush", flush, 0);
    chk("R1 backoff", backoff, 0); chk("R1 irq", irq, 0); chk("R1 status", status, 0);
    cycle();

    // R11 clean frame, R12 ok enabled
    go(); ticks(10); eof = 1; cycle();
    chk("R11 ok status", status, 16'h0820); chk("R12 irq on ok", irq, 1);

    // R4 boundary: 64 ticks is ordinary
    go(); ticks(64); coll = 1; cycle();
    chk("R4 64 ticks normal", status, 16'h0801); chk("R3 backoff", backoff, 1);
    chk("R3 no retry", retry, 0); chk("R12 irq masked", irq, 0);
    // 65 ticks is late
    go(); ticks(65); coll = 1; cycle();
    chk("R4 65 ticks late", status, 16'h1008); chk("R4 retry", retry, 1);
    chk("R4 no backoff", backoff, 0); chk("R10 flush", flush, 1); chk("R10 txrdy low", txrdy, 0);
    cycle();
    chk("R10 retry held", retry, 1); chk("R10 flush single", flush, 0);
    // R2 start ignored during retry
    go(); coll = 1; cycle();
    chk("R2 status kept", status, 16'h1008); chk("R2 no backoff", backoff, 0);
    ack();
    chk("R10 cleared", retry, 0); chk("R10 txrdy back", txrdy, 1);
    go(); eof = 1; cycle();
    chk("R11 attempts 2", status, 16'h1020);

    // R7 one-try
    one = 1; go(); coll = 1; cycle();
    chk("R7 one-try", status, 16'h0801); chk("R7 retry", retry, 1);
    one = 0; ack();
    go(); eof = 1; cycle();
    chk("R11 after one-try", status, 16'h1020);

    // R8 underflow, all flags enabled
    en = 6'h3F;
    go(); ticks(3); under = 1; cycle();
    chk("R8 underflow", status, 16'h0802); chk("R8 retry", retry, 1); chk("R12 irq", irq, 1);
    ack();

    // R9 carrier never asserted
    crs = 0; go(); ticks(2); eof = 1; cycle();
    chk("R9 no carrier", status, 16'h0804); chk("R9 retry", retry, 1);
    ack();
    // R9 carrier dropped
    crs = 1; go(); cycle(); crs = 0; cycle();
    chk("R9 carrier drop", status, 16'h0804); chk("R9 retry drop", retry, 1);
    crs = 1; ack();

    // R5 sixteen collisions, R6 wrap
    for (int i = 1; i <= 16; i++) begin
      go(); coll = 1; cycle();
      if (i == 15) begin chk("R6 count 15", status, 16'h7801); chk("R6 no retry", retry, 0); end
    end
    chk("R5 sixteen", status, 16'h8011); chk("R5 retry", retry, 1); chk("R5 backoff", backoff, 1);
    ack();
    go(); coll = 1; cycle();
    chk("R6 wrap 17th", status, 16'h0801); chk("R6 no retry", retry, 0);
    go(); eof = 1; cycle();
    chk("R11 after wrap", status, 16'h1020);
    cycle();
    summary();
  end
endmodule